// File: doc/BRIEF.md
# Waveform Timer Channel

A single up-counting timer channel that can run as a free-running counter or as an interval timer. Software programs it through a small register port. The count clock comes from one of three places. It can be one of four prescaled taps of the system clock, a slow-clock tick, or a tick from a neighbouring channel for chaining. All of these clocks are single-cycle enable pulses in the system clock domain.

Two compare registers shape a waveform output. A match on the first compare raises the output. A match on the second compare lowers it. The second compare can also restart the counter, or restart it and halt it until software retriggers. A status register with read-to-clear event flags feeds an interrupt line through a mask. Software sets bits of that mask through one write address and clears them through another.

A typical use as a square-wave clock puts the first compare at 0 and the second at half the count range, with the counter free-running. A typical use as an event timer selects restart on the second compare and enables its interrupt.

Top module: `wave_timer_channel`

## Requirements
- R1: After reset the count, status flags, interrupt mask, mode register, waveform output and interrupt output are all zero.
- R2: Mode bits [2:0] choose the count tick. Codes 0 to 3 select the system clock divided by 2, 8, 32 and 128. Code 4 selects the `slowTick` input and code 5 selects the `chainTick` input. Codes 6 and 7 select no tick, so the count holds.
- R3: With mode bit 3 clear, the counter advances by one on each selected tick and rolls from 0xFFFF to 0. The roll sets status bit 2. A second-compare match does not restart the counter in this mode.
- R4: With mode bit 3 set, the tick that brings the count equal to the second compare (address 4) sets status bit 0. The next tick returns the count to 0.
- R5: With mode bits 3 and 4 set, a second-compare match halts counting with the count held at the compare value. Counting resumes only after a software trigger.
- R6: The waveform output goes high on the tick that brings the count to the first compare (address 3). It goes low on the tick that brings the count to the second compare. When both match on the same tick, low wins. A first-compare match sets status bit 1.
- R7: A write to the control address (1) uses three bits. Bit 0 enables the count clock and bit 1 disables it; bit 1 wins when both are set. Bit 2 resets the count to 0 and clears a halt. Status bit 4 reflects the clock enable.
- R8: A write to address 6 sets the mask bits whose data bits [2:0] are one. A write to address 7 clears them. Address 8 reads the mask back.
- R9: The interrupt output is high exactly when some status bit in [2:0] is set and its mask bit is set.
- R10: A read of the status address (5) returns the flags in the same cycle and clears bits [2:0]. An event arriving in the cycle of that read stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (clears status on address 5) |
| regAddr | input | 4 | Register address |
| regWrData | input | 16 | Register write data |
| regRdData | output | 16 | Register read data, combinational from address |
| slowTick | input | 1 | Slow-clock tick enable |
| chainTick | input | 1 | Chained tick enable from a neighbouring channel |
| waveOut | output | 1 | Compare-driven waveform output |
| irqOut | output | 1 | Masked interrupt request |

## Verification
A register write takes effect at the clock edge that captures it. A tick present in a cycle moves the count, the flags and the waveform output at that same edge. The read port and the interrupt line are combinational, so they show the new state right after that edge. The bench drives every input on a falling edge and reads outputs one falling edge later, with exactly the intended number of rising edges in between. Prescaled taps run freely, so those checks use a window of 256 cycles, which holds an exact number of ticks for every divisor whatever the phase.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
  typedef struct packed {
    logic run;
    logic trigger;
    logic autoReset;
  } dpStrobe_t;

  typedef struct packed {
    logic wrap;
    logic raHit;
    logic rcHit;
  } dpEvent_t;

  localparam logic [3:0] ADDR_MODE   = 4'd0;
  localparam logic [3:0] ADDR_CTRL   = 4'd1;
  localparam logic [3:0] ADDR_COUNT  = 4'd2;
  localparam logic [3:0] ADDR_RA     = 4'd3;
  localparam logic [3:0] ADDR_RC     = 4'd4;
  localparam logic [3:0] ADDR_STATUS = 4'd5;
  localparam logic [3:0] ADDR_IEN    = 4'd6;
  localparam logic [3:0] ADDR_IDIS   = 4'd7;
  localparam logic [3:0] ADDR_MASK   = 4'd8;

  localparam logic [2:0] SEL_SLOW  = 3'd4;
  localparam logic [2:0] SEL_CHAIN = 3'd5;
endpackage

// File: rtl/wtc_datapath.sv
module wtc_datapath
  import wtc_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int NUM_DIV = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  logic [2:0]       clkSel,
  input  logic [CNT_W-1:0] raVal,
  input  logic [CNT_W-1:0] rcVal,
  input  logic             slowTick,
  input  logic             chainTick,
  output logic [CNT_W-1:0] count,
  output logic             waveOut,
  output dpEvent_t         events
);
  localparam int PRE_W = 2 * NUM_DIV - 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [PRE_W-1:0] preCnt;
  logic [NUM_DIV-1:0] divTick;
  logic selTick, tick, rcEq, restart;
  logic [CNT_W-1:0] nextCount;

  always_ff @(posedge clk) begin
    if (!rstN) preCnt <= '0;
    else       preCnt <= preCnt + 1'b1;
  end

  // tap i fires once every 2^(2i+1) cycles
  genvar gi;
  generate
    for (gi = 0; gi < NUM_DIV; gi++) begin : g_div
      assign divTick[gi] = &preCnt[2*gi:0];
    end
  endgenerate

  always_comb begin
    selTick = 1'b0;
    if (clkSel == SEL_SLOW)       selTick = slowTick;
    else if (clkSel == SEL_CHAIN) selTick = chainTick;
    else begin
      for (int i = 0; i < NUM_DIV; i++)
        if (clkSel == 3'(i)) selTick = divTick[i];
    end
  end

  assign tick      = strobe.run && selTick && !strobe.trigger;
  assign rcEq      = (count == rcVal);
  assign restart   = strobe.autoReset && rcEq;
  assign nextCount = restart ? '0 : count + 1'b1;

  always_comb begin
    events.rcHit = tick && (nextCount == rcVal);
    events.raHit = tick && (nextCount == raVal);
    events.wrap  = tick && (count == CNT_MAX) && !restart;
  end

  always_ff @(posedge clk) begin
    if (!rstN)               count <= '0;
    else if (strobe.trigger) count <= '0;
    else if (tick)           count <= nextCount;
  end

  always_ff @(posedge clk) begin
    if (!rstN)             waveOut <= 1'b0;
    else if (events.rcHit) waveOut <= 1'b0;
    else if (events.raHit) waveOut <= 1'b1;
  end

  p_trig_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.trigger |=> (count == '0));
  p_free_wrap_r3: assert property (@(posedge clk) disable iff (!rstN)
    (tick && !strobe.autoReset && count == CNT_MAX) |=> (count == '0));
  p_auto_reset_r4: assert property (@(posedge clk) disable iff (!rstN)
    (tick && strobe.autoReset && rcEq) |=> (count == '0));
  p_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.run && !strobe.trigger) |=> $stable(count));
  p_wave_low_r6: assert property (@(posedge clk) disable iff (!rstN)
    events.rcHit |=> !waveOut);
endmodule

// File: rtl/wtc_ctrl.sv
module wtc_ctrl
  import wtc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic             regRdEn,
  input  logic [3:0]       regAddr,
  input  logic [CNT_W-1:0] regWrData,
  input  logic [CNT_W-1:0] count,
  input  dpEvent_t         events,
  output logic [CNT_W-1:0] regRdData,
  output dpStrobe_t        strobe,
  output logic [2:0]       clkSel,
  output logic [CNT_W-1:0] raVal,
  output logic [CNT_W-1:0] rcVal,
  output logic             irqOut
);
  localparam int MODE_W = 5;
  localparam int EVT_W  = 3;

  logic [MODE_W-1:0] modeReg;
  logic [EVT_W-1:0]  maskReg, flags, evVec;
  logic clkEn, halted, ctrlWr, statusRd;

  assign ctrlWr   = regWrEn && (regAddr == ADDR_CTRL);
  assign statusRd = regRdEn && (regAddr == ADDR_STATUS);
  assign evVec    = {events.wrap, events.raHit, events.rcHit};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeReg <= '0;
      raVal   <= '0;
      rcVal   <= '0;
    end else if (regWrEn) begin
      case (regAddr)
        ADDR_MODE: modeReg <= regWrData[MODE_W-1:0];
        ADDR_RA:   raVal   <= regWrData;
        ADDR_RC:   rcVal   <= regWrData;
        default: ;
      endcase
    end
  end

  // disable outranks enable in one write
  always_ff @(posedge clk) begin
    if (!rstN) clkEn <= 1'b0;
    else if (ctrlWr) begin
      if (regWrData[1])      clkEn <= 1'b0;
      else if (regWrData[0]) clkEn <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                            halted <= 1'b0;
    else if (ctrlWr && regWrData[2])      halted <= 1'b0;
    else if (events.rcHit && modeReg[4])  halted <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) maskReg <= '0;
    else if (regWrEn && regAddr == ADDR_IEN)  maskReg <= maskReg | regWrData[EVT_W-1:0];
    else if (regWrEn && regAddr == ADDR_IDIS) maskReg <= maskReg & ~regWrData[EVT_W-1:0];
  end

  // new events outrank the read clear
  always_ff @(posedge clk) begin
    if (!rstN) flags <= '0;
    else       flags <= (statusRd ? '0 : flags) | evVec;
  end

  always_comb begin
    strobe.run       = clkEn && !halted;
    strobe.trigger   = ctrlWr && regWrData[2];
    strobe.autoReset = modeReg[3];
    clkSel           = modeReg[2:0];
    irqOut           = |(flags & maskReg);
  end

  always_comb begin
    case (regAddr)
      ADDR_MODE:   regRdData = CNT_W'(modeReg);
      ADDR_COUNT:  regRdData = count;
      ADDR_RA:     regRdData = raVal;
      ADDR_RC:     regRdData = rcVal;
      ADDR_STATUS: regRdData = CNT_W'({clkEn, 1'b0, flags});
      ADDR_MASK:   regRdData = CNT_W'(maskReg);
      default:     regRdData = '0;
    endcase
  end

  p_clk_off_r7: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && regWrData[1]) |=> !clkEn);
  p_stop_halt_r5: assert property (@(posedge clk) disable iff (!rstN)
    (events.rcHit && modeReg[4] && !ctrlWr) |=> !strobe.run);
  p_mask_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == ADDR_IDIS && regWrData[EVT_W-1:0] == '1) |=> (maskReg == '0));
  p_event_wins_r10: assert property (@(posedge clk) disable iff (!rstN)
    events.rcHit |=> flags[0]);
endmodule

// File: rtl/wave_timer_channel.sv
module wave_timer_channel
  import wtc_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int NUM_DIV = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic             regRdEn,
  input  logic [3:0]       regAddr,
  input  logic [CNT_W-1:0] regWrData,
  output logic [CNT_W-1:0] regRdData,
  input  logic             slowTick,
  input  logic             chainTick,
  output logic             waveOut,
  output logic             irqOut
);
  dpStrobe_t        strobe;
  dpEvent_t         events;
  logic [2:0]       clkSel;
  logic [CNT_W-1:0] raVal, rcVal, count;

  wtc_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .count(count), .events(events),
    .regRdData(regRdData), .strobe(strobe), .clkSel(clkSel),
    .raVal(raVal), .rcVal(rcVal), .irqOut(irqOut)
  );

  wtc_datapath #(.CNT_W(CNT_W), .NUM_DIV(NUM_DIV)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .clkSel(clkSel),
    .raVal(raVal), .rcVal(rcVal), .slowTick(slowTick), .chainTick(chainTick),
    .count(count), .waveOut(waveOut), .events(events)
  );

  p_irq_masked_r9: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == ADDR_IDIS && regWrData[2:0] == 3'b111) |=> !irqOut);
endmodule

// File: tb/wave_timer_channel_tb.sv
module wave_timer_channel_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0, regRdEn = 1'b0;
  logic [3:0] regAddr = '0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic slowTick = 1'b0, chainTick = 1'b0;
  logic waveOut, irqOut;
  int vectors = 0, misses = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  wave_timer_channel u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .slowTick(slowTick), .chainTick(chainTick), .waveOut(waveOut), .irqOut(irqOut)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk); regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk); regRdEn = 1'b1; regAddr = a;
    #1 d = regRdData;
    @(negedge clk); regRdEn = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk); chainTick = 1'b1;
    repeat (n) @(negedge clk);
    chainTick = 1'b0;
  endtask

  task automatic start(input logic [15:0] mode);
    wr(4'd0, mode);
    wr(4'd1, 16'h0005);
  endtask

  task automatic t_reset;
    logic [15:0] v;
    rd(4'd2, v); chk("R1 count", v, 16'h0);
    rd(4'd5, v); chk("R1 status", v, 16'h0);
    rd(4'd8, v); chk("R1 mask", v, 16'h0);
    rd(4'd0, v); chk("R1 mode", v, 16'h0);
    chk("R1 wave", {15'b0, waveOut}, 16'h0);
    chk("R1 irq", {15'b0, irqOut}, 16'h0);
  endtask

  task automatic t_free;
    logic [15:0] v;
    wr(4'd3, 16'hFFF0); wr(4'd4, 16'h0002);
    start(16'd5);
    ticks(5);
    rd(4'd2, v); chk("R3 rc no restart", v, 16'd5);
    wr(4'd0, 16'd6);
    ticks(3);
    rd(4'd2, v); chk("R2 code6 holds", v, 16'd5);
  endtask

  task automatic t_square;
    logic [15:0] v;
    wr(4'd3, 16'h0000); wr(4'd4, 16'h8000);
    start(16'd5);
    rd(4'd5, v);
    ticks(32'h8000);
    rd(4'd2, v); chk("R3 half count", v, 16'h8000);
    chk("R6 wave low at rc", {15'b0, waveOut}, 16'h0);
    rd(4'd5, v); chk("R6 rc flag", v, 16'h0011);
    ticks(32'h8000);
    rd(4'd2, v); chk("R3 wrap to zero", v, 16'h0000);
    chk("R6 wave high at ra", {15'b0, waveOut}, 16'h1);
    rd(4'd5, v); chk("R3 wrap flag", v, 16'h0016);
    ticks(32'h8000);
    chk("R6 wave low again", {15'b0, waveOut}, 16'h0);
  endtask

  task automatic t_wave_eq;
    wr(4'd3, 16'd1); wr(4'd4, 16'd7);
    start(16'd5);
    ticks(1);
    chk("R6 wave set", {15'b0, waveOut}, 16'h1);
    wr(4'd3, 16'd3); wr(4'd4, 16'd3);
    ticks(2);
    chk("R6 rc wins tie", {15'b0, waveOut}, 16'h0);
  endtask

  task automatic t_auto;
    logic [15:0] v;
    wr(4'd3, 16'h0100); wr(4'd4, 16'd3);
    start(16'd13);
    rd(4'd5, v);
    ticks(3);
    rd(4'd2, v); chk("R4 reach rc", v, 16'd3);
    rd(4'd5, v); chk("R4 rc flag", v, 16'h0011);
    ticks(1);
    rd(4'd2, v); chk("R4 restart", v, 16'd0);
    ticks(2);
    rd(4'd2, v); chk("R4 counts on", v, 16'd2);
  endtask

  task automatic t_stop;
    logic [15:0] v;
    wr(4'd4, 16'd4);
    start(16'd29);
    rd(4'd5, v);
    ticks(6);
    rd(4'd2, v); chk("R5 halted at rc", v, 16'd4);
    rd(4'd5, v); chk("R5 clock still on", v, 16'h0011);
    wr(4'd1, 16'h0004);
    rd(4'd2, v); chk("R7 trigger zero", v, 16'd0);
    ticks(2);
    rd(4'd2, v); chk("R5 resumed", v, 16'd2);
  endtask

  task automatic t_ctrl;
    logic [15:0] v;
    wr(4'd4, 16'h0100);
    start(16'd5);
    ticks(2);
    wr(4'd1, 16'h0003);
    rd(4'd5, v); chk("R7 disable wins", v & 16'h0010, 16'h0000);
    ticks(3);
    rd(4'd2, v); chk("R7 disabled holds", v, 16'd2);
    wr(4'd1, 16'h0001);
    ticks(1);
    rd(4'd2, v); chk("R7 enable resumes", v, 16'd3);
  endtask

  task automatic t_irq;
    logic [15:0] v;
    wr(4'd7, 16'h00FF);
    wr(4'd4, 16'd2);
    start(16'd13);
    rd(4'd5, v);
    ticks(2);
    chk("R9 masked no irq", {15'b0, irqOut}, 16'h0);
    wr(4'd6, 16'h0001);
    rd(4'd8, v); chk("R8 mask set", v, 16'h0001);
    chk("R9 irq raised", {15'b0, irqOut}, 16'h1);
    wr(4'd6, 16'h0004);
    rd(4'd8, v); chk("R8 mask accumulates", v, 16'h0005);
    wr(4'd7, 16'h00FF);
    rd(4'd8, v); chk("R8 mask cleared", v, 16'h0000);
    chk("R9 irq dropped", {15'b0, irqOut}, 16'h0);
  endtask

  task automatic t_rdclr;
    logic [15:0] v;
    rd(4'd5, v); chk("R10 first read", v & 16'h0001, 16'h0001);
    rd(4'd5, v); chk("R10 cleared", v, 16'h0010);
    wr(4'd4, 16'd1);
    start(16'd13);
    rd(4'd5, v);
    @(negedge clk); chainTick = 1'b1; regRdEn = 1'b1; regAddr = 4'd5;
    @(negedge clk); chainTick = 1'b0; regRdEn = 1'b0;
    rd(4'd5, v); chk("R10 event wins", v & 16'h0001, 16'h0001);
  endtask

  task automatic t_presc;
    logic [15:0] v;
    for (int s = 0; s < 4; s++) begin
      start(16'(s));
      repeat (255) @(negedge clk);
      rd(4'd2, v);
      chk($sformatf("R2 divider code %0d", s), v, 16'(256 >> (2 * s + 1)));
    end
    start(16'd4);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); slowTick = 1'b1;
      @(negedge clk); slowTick = 1'b0;
    end
    rd(4'd2, v); chk("R2 slow tick", v, 16'd3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_free();
    t_square();
    t_wave_eq();
    t_auto();
    t_stop();
    t_ctrl();
    t_irq();
    t_rdclr();
    t_presc();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      vectors++;
      misses++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end
endmodule